// File: doc/BRIEF.md
# Cascadable Synchronous Presettable Counter

A four-bit counter whose register advances on the rising clock edge. The counter can be preset from a parallel data bus and cleared through an active-low clear. It advances only when two count-enable inputs are both high. A carry output goes high while the counter sits at its terminal value, but only when the second enable is also high. Because that enable is fed forward to the carry, stages chain with no extra gates. Each stage's carry drives the next stage's second enable. All first enables share one common count enable, and all stages share one clock.

Two parameters select the variant. `DECADE` picks a binary sequence (0 to 15) or a decade sequence (0 to 9). `ASYNC_CLR` picks a clear that acts at the next clock edge or one that acts at once, without a clock. Control changes other than the asynchronous clear take effect only at the next rising edge.

Top module: `cascnt4`

## Requirements
- R1: When clear and load are inactive (high) and both `en_p` and `en_t` are high, `q` advances by one on the rising clock edge.
- R2: When clear and load are inactive and either `en_p` or `en_t` is low, `q` keeps its value across the clock edge.
- R3: When `ld_n` is low and clear is inactive, `q` takes `din` at the next rising edge, whatever the enable levels.
- R4: With `ASYNC_CLR`=0, a low `clr_n` makes `q` zero at the next rising edge, whatever the levels of `ld_n`, `en_p` and `en_t`. Clear wins over load, and `q` does not change before that edge.
- R5: With `ASYNC_CLR`=1, a low `clr_n` forces `q` to zero at once, with no clock edge, and holds it at zero while low.
- R6: In binary mode the count wraps from 15 to 0. In decade mode it wraps from 9 to 0.
- R7: `rco` is high exactly when `en_t` is high and `q` equals the terminal value (15 binary, 9 decade). It does not depend on `en_p`.
- R8: In decade mode, a counting edge taken from any loaded value of 10 to 15 returns `q` to 0, and no carry is produced at those values.
- R9: Chaining stages with each `rco` driving the next stage's `en_t`, and with shared clock, clear, load and `en_p`, gives a wider binary counter whose last carry marks the all-ones value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on the rising edge |
| clr_n | input | 1 | Active-low clear (synchronous or asynchronous by parameter) |
| ld_n | input | 1 | Active-low parallel preset |
| en_p | input | 1 | Count enable that does not reach the carry |
| en_t | input | 1 | Count enable that also gates the carry |
| din | input | W | Preset data |
| q | output | W | Current count |
| rco | output | 1 | Terminal-count carry, gated by `en_t` |

## Verification
The bench drives the stimulus to a synchronous binary stage, an asynchronous decade stage and a three-stage binary chain at the same time. It aims at the corners where a wrong design shows up.

A carry gated by `en_p` would drop while counting is paused at terminal count. A decade stage that only wraps at exactly 9 would run from 12 on to 13. A clear that loses to load would preset the data instead of zero. A synchronous clear that acted at once would zero the count mid-cycle. An asynchronous clear that waited for the clock would leave the old value visible.

For the chain, the bench preloads values next to the nibble boundaries. A chain that leaked carries would fail to propagate from one stage to the next, or would advance the upper stages early.

// File: rtl/cascnt_pkg.sv
package cascnt_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } cnt_op_e;

    // Last value of the sequence before it wraps to zero.
    function automatic int unsigned term_of(int unsigned w, bit dec);
        return dec ? 32'd9 : ((32'd1 << w) - 32'd1);
    endfunction

endpackage

// File: rtl/cascnt_ctl.sv
module cascnt_ctl #(
    parameter bit ASYNC_CLR = 1'b0
) (
    input  logic                 clr_n,
    input  logic                 ld_n,
    input  logic                 en_p,
    input  logic                 en_t,
    output cascnt_pkg::cnt_op_e  op
);
    // Priority: clear, load, count, hold. An asynchronous clear is handled
    // by the register itself, so it is not decoded here.
    always_comb begin
        if (!clr_n && !ASYNC_CLR) begin
            op = cascnt_pkg::OP_CLEAR;
        end else if (!ld_n) begin
            op = cascnt_pkg::OP_LOAD;
        end else if (en_p && en_t) begin
            op = cascnt_pkg::OP_COUNT;
        end else begin
            op = cascnt_pkg::OP_HOLD;
        end
    end
endmodule

// File: rtl/cascnt_next.sv
module cascnt_next #(
    parameter int unsigned W      = 4,
    parameter bit          DECADE = 1'b0
) (
    input  cascnt_pkg::cnt_op_e op,
    input  logic [W-1:0]        cur,
    input  logic [W-1:0]        din,
    output logic [W-1:0]        nxt
);
    localparam logic [W-1:0] TERM = W'(cascnt_pkg::term_of(W, DECADE));

    logic [W-1:0] inc;

    // Values at or past the terminal value return to zero, which also
    // recovers out-of-range presets in decade mode.
    always_comb begin
        if (cur >= TERM) begin
            inc = '0;
        end else begin
            inc = cur + W'(1);
        end
    end

    always_comb begin
        unique case (op)
            cascnt_pkg::OP_CLEAR: nxt = '0;
            cascnt_pkg::OP_LOAD:  nxt = din;
            cascnt_pkg::OP_COUNT: nxt = inc;
            default:              nxt = cur;
        endcase
    end
endmodule

// File: rtl/cascnt_term.sv
module cascnt_term #(
    parameter int unsigned W      = 4,
    parameter bit          DECADE = 1'b0
) (
    input  logic [W-1:0] cur,
    input  logic         en_t,
    output logic         rco
);
    localparam logic [W-1:0] TERM = W'(cascnt_pkg::term_of(W, DECADE));

    always_comb begin
        rco = en_t && (cur == TERM);
    end
endmodule

// File: rtl/cascnt4.sv
module cascnt4 #(
    parameter int unsigned W         = 4,
    parameter bit          DECADE    = 1'b0,
    parameter bit          ASYNC_CLR = 1'b0
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         ld_n,
    input  logic         en_p,
    input  logic         en_t,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         rco
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t             st_d;
    cnt_st_t             st_q;
    cascnt_pkg::cnt_op_e op;
    logic [W-1:0]        nxt;

    cascnt_ctl #(.ASYNC_CLR(ASYNC_CLR)) u_ctl (
        .clr_n (clr_n),
        .ld_n  (ld_n),
        .en_p  (en_p),
        .en_t  (en_t),
        .op    (op)
    );

    cascnt_next #(.W(W), .DECADE(DECADE)) u_next (
        .op  (op),
        .cur (st_q.cnt),
        .din (din),
        .nxt (nxt)
    );

    cascnt_term #(.W(W), .DECADE(DECADE)) u_term (
        .cur  (st_q.cnt),
        .en_t (en_t),
        .rco  (rco)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cnt = nxt;
    end

    generate
        if (ASYNC_CLR) begin : g_aclr
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end
        end else begin : g_sclr
            always_ff @(posedge clk) begin
                st_q <= st_d;
            end
        end
    endgenerate

    assign q = st_q.cnt;
endmodule

// File: rtl/cascnt4_chk.sv
module cascnt4_chk #(
    parameter int unsigned W         = 4,
    parameter bit          DECADE    = 1'b0,
    parameter bit          ASYNC_CLR = 1'b0
) (
    input logic         clk,
    input logic         clr_n,
    input logic         ld_n,
    input logic         en_p,
    input logic         en_t,
    input logic [W-1:0] din,
    input logic [W-1:0] q,
    input logic         rco
);
    localparam logic [W-1:0] TERM = W'(cascnt_pkg::term_of(W, DECADE));

    logic started = 1'b0;
    always_ff @(posedge clk) started <= 1'b1;

    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (!started || !clr_n)
        (ld_n && en_p && en_t && q < TERM) |=> q == $past(q) + W'(1));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!started || !clr_n)
        (ld_n && !(en_p && en_t)) |=> $stable(q));

    // R3
    preset_chk: assert property (@(posedge clk) disable iff (!started || !clr_n)
        !ld_n |=> q == $past(din));

    // R6 R8
    wrap_chk: assert property (@(posedge clk) disable iff (!started || !clr_n)
        (ld_n && en_p && en_t && q >= TERM) |=> q == '0);

    // R7
    carry_gate_chk: assert property (@(posedge clk) disable iff (!started)
        !en_t |-> !rco);

    // R7
    carry_term_chk: assert property (@(posedge clk) disable iff (!started)
        rco |-> q == TERM);

    generate
        if (ASYNC_CLR) begin : g_aclr_chk
            // R5
            aclr_zero_chk: assert property (@(posedge clk) disable iff (!started)
                !clr_n |-> q == '0);
        end else begin : g_sclr_chk
            // R4
            sclr_zero_chk: assert property (@(posedge clk) disable iff (!started)
                !clr_n |=> q == '0);
        end
    endgenerate
endmodule

bind cascnt4 cascnt4_chk #(.W(W), .DECADE(DECADE), .ASYNC_CLR(ASYNC_CLR)) u_chk (
    .clk   (clk),
    .clr_n (clr_n),
    .ld_n  (ld_n),
    .en_p  (en_p),
    .en_t  (en_t),
    .din   (din),
    .q     (q),
    .rco   (rco)
);

// File: tb/cascnt4_tb.sv
module cascnt4_tb;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        clr_n = 1'b1;
    logic        ld_n  = 1'b1;
    logic        en_p  = 1'b0;
    logic        en_t  = 1'b0;
    logic [3:0]  din   = 4'h0;

    logic [3:0]  q, dq;
    logic        rco, drco;
    logic [11:0] cas_q;
    logic [2:0]  cas_rco;
    logic [2:0]  cas_ent;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    cascnt4 #(.W(4), .DECADE(1'b0), .ASYNC_CLR(1'b0)) u_dut (
        .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .en_p(en_p), .en_t(en_t),
        .din(din), .q(q), .rco(rco)
    );

    cascnt4 #(.W(4), .DECADE(1'b1), .ASYNC_CLR(1'b1)) u_dec (
        .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .en_p(en_p), .en_t(en_t),
        .din(din), .q(dq), .rco(drco)
    );

    // R9: three binary stages, carry of each into en_t of the next.
    assign cas_ent = {cas_rco[1:0], en_t};
    for (genvar k = 0; k < 3; k++) begin : g_cas
        cascnt4 #(.W(4), .DECADE(1'b0), .ASYNC_CLR(1'b0)) u_st (
            .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .en_p(en_p), .en_t(cas_ent[k]),
            .din(din), .q(cas_q[4*k +: 4]), .rco(cas_rco[k])
        );
    end

    typedef struct {
        logic [3:0]  q;
        logic        r;
        logic [3:0]  dq;
        logic        dr;
        logic [11:0] c;
        logic        cr;
        string       tag;
    } item_t;

    item_t sb[$];

    logic [3:0]  m_q = 'x;
    logic [3:0]  m_d = 'x;
    logic [11:0] m_c = 'x;

    function automatic void chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endfunction

    task automatic step(input logic c, input logic l, input logic p, input logic t,
                        input logic [3:0] d, input string tag);
        item_t it;
        @(negedge clk);
        clr_n = c; ld_n = l; en_p = p; en_t = t; din = d;
        if (!c && m_d != 4'd0) begin
            #1;
            chk({tag, " R5 async clear acts at once"}, 16'(dq), 16'(0));
            chk({tag, " R4 sync clear waits for edge"}, 16'(q), 16'(m_q));
        end
        if (!c) begin
            m_q = '0; m_d = '0; m_c = '0;
        end else if (!l) begin
            m_q = d; m_d = d; m_c = {d, d, d};
        end else if (p && t) begin
            m_q = m_q + 4'd1;
            m_d = (m_d >= 4'd9) ? 4'd0 : m_d + 4'd1;
            m_c = m_c + 12'd1;
        end
        it.q  = m_q; it.r  = t && (m_q == 4'hF);
        it.dq = m_d; it.dr = t && (m_d == 4'd9);
        it.c  = m_c; it.cr = t && (m_c == 12'hFFF);
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: after each rising edge, inputs are still held until the falling edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                chk({it.tag, " bin q"},     16'(q),       16'(it.q));
                chk({it.tag, " bin rco"},   16'(rco),     16'(it.r));
                chk({it.tag, " dec q"},     16'(dq),      16'(it.dq));
                chk({it.tag, " dec rco"},   16'(drco),    16'(it.dr));
                chk({it.tag, " R9 chain"},  16'(cas_q),   16'(it.c));
                chk({it.tag, " R9 carry"},  16'(cas_rco[2]), 16'(it.cr));
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        step(1'b0, 1'b1, 1'b1, 1'b1, 4'h0, "R4 R5 reset state");
        step(1'b0, 1'b0, 1'b0, 1'b0, 4'h3, "R4 R5 reset state held");
        repeat (20) step(1'b1, 1'b1, 1'b1, 1'b1, 4'h0, "R1 R6 R7 counting");
        step(1'b1, 1'b0, 1'b0, 1'b0, 4'hF, "R3 preset with enables low");
        step(1'b1, 1'b1, 1'b0, 1'b1, 4'h0, "R2 R7 hold en_p low carry stays");
        step(1'b1, 1'b1, 1'b0, 1'b1, 4'h5, "R2 R7 hold en_p low again");
        step(1'b1, 1'b1, 1'b1, 1'b0, 4'h0, "R2 R7 hold en_t low no carry");
        step(1'b1, 1'b1, 1'b1, 1'b0, 4'h0, "R2 hold en_t low again");
        step(1'b1, 1'b1, 1'b1, 1'b1, 4'h0, "R6 R8 R9 wrap from all ones");
        step(1'b1, 1'b0, 1'b1, 1'b1, 4'd12, "R3 R8 preset 12");
        step(1'b1, 1'b1, 1'b1, 1'b1, 4'h0, "R8 decade from 12 to 0");
        step(1'b1, 1'b0, 1'b1, 1'b1, 4'd9, "R3 preset 9");
        step(1'b1, 1'b1, 1'b0, 1'b1, 4'h0, "R7 decade carry at 9");
        step(1'b1, 1'b1, 1'b1, 1'b1, 4'h0, "R6 decade wrap 9 to 0");
        step(1'b1, 1'b0, 1'b1, 1'b1, 4'hE, "R3 R9 preset EEE");
        repeat (3) step(1'b1, 1'b1, 1'b1, 1'b1, 4'h0, "R9 carry across stages");
        step(1'b0, 1'b0, 1'b1, 1'b1, 4'h7, "R4 R5 clear beats load");
        step(1'b1, 1'b1, 1'b1, 1'b1, 4'h0, "R1 count after clear");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule